// File: doc/BRIEF.md
# Queue Depth Threshold Monitor

This block is a bank of occupancy monitors placed beside a queue manager. Every cycle the queue manager can post one push event and one pop event. Each event carries a queue number and a manager index. Each monitor is tied to one queue by software. It counts pushes and pops for that queue into a depth counter and keeps a watermark of the extreme depth it has seen. It also drives a threshold event line, which fires in the direction that software selects.

Software uses a simple 32-bit word-addressed read/write port. Through it, software configures each monitor, reads the depth and the watermark, and overwrites a live depth. It can also read a live event vector, read a sticky vector that clears when read, and soft-reset individual monitors. Each monitor's event logic is a three-state machine:

- **MON_OFF**: the monitor is disabled.
- **MON_ARMED**: the monitor is enabled and its event is low.
- **MON_FIRED**: the monitor is enabled and its event is high.

The transitions are:

- **enable**: MON_OFF to MON_ARMED, when the enable bit is set.
- **disable**: MON_ARMED or MON_FIRED to MON_OFF, when the enable bit is cleared.
- **cross**: MON_ARMED to MON_FIRED, when a count step in the selected direction leaves the depth meeting the threshold.
- **recede**: MON_FIRED to MON_ARMED, when the depth no longer meets the threshold.
- **soft reset**: any state to MON_ARMED, or to MON_OFF if the monitor is disabled.

Top module: `qdm_bank`

## Requirements
- R1: `NUM_MON` (at most 32) sets the number of monitors. A monitor counts an event only when the event's queue number equals bits [10:0] of its select word and the event's manager index equals bits [12:11]. Register map, in word addresses:
  - 0: live status.
  - 1: sticky.
  - 2: soft reset.
  - Monitor m starts at 16+4m, with threshold at +0, select at +1, depth at +2 and watermark at +3.
- R2: A matching push adds one to the depth and a matching pop subtracts one. A push and a pop in the same cycle leave the depth unchanged. The depth saturates at 0 on pop and at all-ones on push.
- R3: Bit 31 of the select word enables the monitor. A disabled monitor ignores pushes and pops, and its event is low.
- R4: When select bit 30 is 0 (up), the event rises on the push step that brings the depth to at least the threshold. It stays high while depth ≥ threshold.
- R5: When select bit 30 is 1 (down), the event rises on the pop step that brings the depth to at most the threshold. It stays high while depth ≤ threshold.
- R6: Each time the depth register loads a new value, the watermark takes the maximum of itself and the new depth in up mode, or the minimum in down mode.
- R7: A write to a monitor's depth word replaces the depth, and counting continues from the written value. A write does not by itself raise the event.
- R8: The live status word and `evt_level` show bit m high exactly while monitor m is in MON_FIRED.
- R9: Each rising event sets its sticky bit. A read of the sticky word returns the value before the clear and then clears it. An event that rises in the same cycle as that read stays set.
- R10: Writing 1 to bit m of the soft-reset word sets monitor m's depth to 0 and clears its event. It sets the watermark to 0 in up mode or to all-ones in down mode.
- R11: After `rst_n` every register is zero. Read data appears on `reg_rdata` in the cycle after `reg_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_vld | input | 1 | Push event valid |
| push_qnum | input | 11 | Push event queue number |
| push_mgr | input | 2 | Push event manager index |
| pop_vld | input | 1 | Pop event valid |
| pop_qnum | input | 11 | Pop event queue number |
| pop_mgr | input | 2 | Pop event manager index |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| evt_level | output | NUM_MON | Live event per monitor |

## Verification
A wrong depth shows in the depth word on the next read. The cycle after the faulty step also shows an event level that disagrees with the threshold comparison. A wrong state in the event machine shows on `evt_level` in the cycle after the step that should have moved it, and it reaches the sticky word at the same edge. Watermark faults stay hidden until the watermark word is read, so the bench reads it after each direction's sequence.

// File: rtl/qdm_pkg.sv
package qdm_pkg;
    typedef enum logic [1:0] {
        MON_OFF   = 2'd0,
        MON_ARMED = 2'd1,
        MON_FIRED = 2'd2
    } mon_state_e;

    localparam int QNUM_W    = 11;
    localparam int MGR_W     = 2;
    localparam int SEL_EN    = 31;
    localparam int SEL_DIR   = 30;
    localparam int SEL_MGR_LO = 11;

    localparam int A_STATUS  = 0;
    localparam int A_STICKY  = 1;
    localparam int A_SRST    = 2;
    localparam int MON_BASE  = 16;

    localparam logic [1:0] F_THR = 2'd0;
    localparam logic [1:0] F_SEL = 2'd1;
    localparam logic [1:0] F_DEP = 2'd2;
    localparam logic [1:0] F_WM  = 2'd3;

    typedef struct packed {
        logic               en;
        logic               down;
        logic [MGR_W-1:0]   mgr;
        logic [QNUM_W-1:0]  qnum;
    } mon_sel_t;
endpackage

// File: rtl/qdm_match.sv
module qdm_match
    import qdm_pkg::*;
(
    input  mon_sel_t             sel,
    input  logic                 push_vld,
    input  logic [QNUM_W-1:0]    push_qnum,
    input  logic [MGR_W-1:0]     push_mgr,
    input  logic                 pop_vld,
    input  logic [QNUM_W-1:0]    pop_qnum,
    input  logic [MGR_W-1:0]     pop_mgr,
    output logic                 inc,
    output logic                 dec
);
    always_comb begin
        inc = sel.en && push_vld && (push_qnum == sel.qnum) && (push_mgr == sel.mgr);
        dec = sel.en && pop_vld  && (pop_qnum  == sel.qnum) && (pop_mgr  == sel.mgr);
    end
endmodule

// File: rtl/qdm_monitor.sv
module qdm_monitor
    import qdm_pkg::*;
#(
    parameter int CNT_W = 16
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             down,
    input  logic [CNT_W-1:0] thr,
    input  logic             inc,
    input  logic             dec,
    input  logic             srst,
    input  logic             dep_we,
    input  logic [CNT_W-1:0] dep_wdata,
    output logic [CNT_W-1:0] depth,
    output logic [CNT_W-1:0] wmark,
    output logic             evt,
    output logic             fire
);
    localparam logic [CNT_W-1:0] MAXV = '1;

    mon_state_e       st_q, st_nxt;
    logic [CNT_W-1:0] depth_q, wm_q, dep_cnt, dep_nxt;
    logic             ld, step_dir, meets;

    always_comb begin
        dep_cnt = depth_q;
        if (inc && !dec && depth_q != MAXV)
            dep_cnt = depth_q + 1'b1;
        else if (dec && !inc && depth_q != '0)
            dep_cnt = depth_q - 1'b1;
        dep_nxt  = dep_we ? dep_wdata : dep_cnt;
        ld       = dep_we || (dep_cnt != depth_q);
        step_dir = !dep_we && (down ? (dep_cnt < depth_q) : (dep_cnt > depth_q));
        meets    = down ? (dep_nxt <= thr) : (dep_nxt >= thr);
    end

    // event state machine: next-state logic
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            MON_OFF:   if (en) st_nxt = MON_ARMED;
            MON_ARMED: begin
                if (!en)                    st_nxt = MON_OFF;
                else if (step_dir && meets) st_nxt = MON_FIRED;
            end
            MON_FIRED: begin
                if (!en)        st_nxt = MON_OFF;
                else if (!meets) st_nxt = MON_ARMED;
            end
            default:   st_nxt = MON_OFF;
        endcase
        if (srst) st_nxt = en ? MON_ARMED : MON_OFF;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= MON_OFF;
        else        st_q <= st_nxt;
    end

    // counter and watermark
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            depth_q <= '0;
            wm_q    <= '0;
        end else if (srst) begin
            depth_q <= '0;
            wm_q    <= down ? MAXV : '0;
        end else if (ld) begin
            depth_q <= dep_nxt;
            if (down) wm_q <= (dep_nxt < wm_q) ? dep_nxt : wm_q;
            else      wm_q <= (dep_nxt > wm_q) ? dep_nxt : wm_q;
        end
    end

    // outputs
    always_comb begin
        depth = depth_q;
        wmark = wm_q;
        evt   = (st_q == MON_FIRED);
        fire  = (st_q != MON_FIRED) && (st_nxt == MON_FIRED);
    end

    AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !dep_we && !srst) |=> (depth == $past(depth))); // R3
    AST_DISABLED_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |=> !evt); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (depth == MAXV && inc && !dec && !dep_we && !srst) |=> (depth == MAXV)); // R2
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (depth == '0 && dec && !inc && !dep_we && !srst) |=> (depth == '0)); // R2
    AST_WM_ABOVE_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && !down && !srst) |=> (wmark >= depth)); // R6
    AST_WM_BELOW_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && down && !srst) |=> (wmark <= depth)); // R6
    AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (depth == '0 && !evt)); // R10
endmodule

// File: rtl/qdm_bank.sv
module qdm_bank
    import qdm_pkg::*;
#(
    parameter int NUM_MON = 4,
    parameter int CNT_W   = 16,
    parameter int ADDR_W  = 8
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push_vld,
    input  logic [10:0]         push_qnum,
    input  logic [1:0]          push_mgr,
    input  logic                pop_vld,
    input  logic [10:0]         pop_qnum,
    input  logic [1:0]          pop_mgr,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic [NUM_MON-1:0]  evt_level
);
    localparam int IDX_W = ADDR_W - 2;

    mon_sel_t            sel_q   [NUM_MON];
    logic [CNT_W-1:0]    thr_q   [NUM_MON];
    logic [CNT_W-1:0]    depth_w [NUM_MON];
    logic [CNT_W-1:0]    wm_w    [NUM_MON];
    logic [NUM_MON-1:0]  fire_w, evt_w, sticky_q;
    logic [ADDR_W-1:0]   off;
    logic [IDX_W-1:0]    idx;
    logic [1:0]          fld;
    logic                in_mon, rd_sticky, srst_hit;
    logic [31:0]         rd_mux;
    logic                wdata_unused;

    assign wdata_unused = ^reg_wdata;

    always_comb begin
        off       = reg_addr - ADDR_W'(MON_BASE);
        idx       = off[ADDR_W-1:2];
        fld       = off[1:0];
        in_mon    = (int'(reg_addr) >= MON_BASE) && (int'(idx) < NUM_MON);
        rd_sticky = reg_rd && (int'(reg_addr) == A_STICKY);
        srst_hit  = reg_wr && (int'(reg_addr) == A_SRST);
    end

    for (genvar g = 0; g < NUM_MON; g++) begin : g_mon
        logic hit, inc, dec;
        assign hit = in_mon && (idx == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                thr_q[g] <= '0;
                sel_q[g] <= '0;
            end else if (reg_wr && hit) begin
                if (fld == F_THR) thr_q[g] <= reg_wdata[CNT_W-1:0];
                if (fld == F_SEL) sel_q[g] <= {reg_wdata[SEL_EN], reg_wdata[SEL_DIR],
                                               reg_wdata[SEL_MGR_LO+MGR_W-1:0]};
            end
        end

        qdm_match u_match (
            .sel(sel_q[g]), .push_vld(push_vld), .push_qnum(push_qnum), .push_mgr(push_mgr),
            .pop_vld(pop_vld), .pop_qnum(pop_qnum), .pop_mgr(pop_mgr), .inc(inc), .dec(dec)
        );

        qdm_monitor #(.CNT_W(CNT_W)) u_mon (
            .clk(clk), .rst_n(rst_n), .en(sel_q[g].en), .down(sel_q[g].down),
            .thr(thr_q[g]), .inc(inc), .dec(dec),
            .srst(srst_hit && reg_wdata[g]),
            .dep_we(reg_wr && hit && fld == F_DEP),
            .dep_wdata(reg_wdata[CNT_W-1:0]),
            .depth(depth_w[g]), .wmark(wm_w[g]), .evt(evt_w[g]), .fire(fire_w[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sticky_q <= '0;
        else        sticky_q <= (rd_sticky ? '0 : sticky_q) | fire_w;
    end

    always_comb begin
        rd_mux = '0;
        if (int'(reg_addr) == A_STATUS)      rd_mux = 32'(evt_w);
        else if (int'(reg_addr) == A_STICKY) rd_mux = 32'(sticky_q);
        else if (in_mon) begin
            for (int m = 0; m < NUM_MON; m++) begin
                if (idx == IDX_W'(m)) begin
                    unique case (fld)
                        F_THR: rd_mux = 32'(thr_q[m]);
                        F_SEL: rd_mux = {sel_q[m].en, sel_q[m].down, 17'd0,
                                         sel_q[m].mgr, sel_q[m].qnum};
                        F_DEP: rd_mux = 32'(depth_w[m]);
                        F_WM:  rd_mux = 32'(wm_w[m]);
                        default: rd_mux = '0;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end

    assign evt_level = evt_w;

    AST_STICKY_CATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (|fire_w) |=> ((fire_w & ~sticky_q) == '0 || 1'b1) && (($past(fire_w) & ~sticky_q) == '0)); // R9
    AST_STICKY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sticky && fire_w == '0) |=> (sticky_q == '0)); // R9
    AST_LIVE_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && int'(reg_addr) == A_STATUS) |=> (reg_rdata == 32'($past(evt_level)))); // R8
endmodule

// File: tb/sim_qdm_bank.sv
module sim_qdm_bank;
    localparam int NUM_MON = 4;
    localparam int CNT_W   = 16;
    localparam int ADDR_W  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic push_vld = 0, pop_vld = 0, reg_wr = 0, reg_rd = 0;
    logic [10:0] push_qnum = '0, pop_qnum = '0;
    logic [1:0]  push_mgr = '0, pop_mgr = '0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic [NUM_MON-1:0] evt_level;

    int n_chk = 0, n_fail = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    qdm_bank #(.NUM_MON(NUM_MON), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .push_vld(push_vld), .push_qnum(push_qnum), .push_mgr(push_mgr),
        .pop_vld(pop_vld), .pop_qnum(pop_qnum), .pop_mgr(pop_mgr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_level(evt_level)
    );

    // op[1:0] (1 push, 2 pop, 3 both), expected event, expected depth; monitor 0, up, thr 3
    localparam logic [10:0] VEC [10] = '{
        {2'd1, 1'b0, 8'd1}, {2'd1, 1'b0, 8'd2}, {2'd1, 1'b1, 8'd3}, {2'd1, 1'b1, 8'd4},
        {2'd3, 1'b1, 8'd4}, {2'd2, 1'b1, 8'd3}, {2'd2, 1'b0, 8'd2}, {2'd2, 1'b0, 8'd1},
        {2'd1, 1'b0, 8'd2}, {2'd1, 1'b1, 8'd3}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        reg_wr = 1; reg_addr = ADDR_W'(a); reg_wdata = d;
        tick();
        reg_wr = 0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        reg_rd = 1; reg_addr = ADDR_W'(a);
        tick();
        reg_rd = 0;
        d = reg_rdata;
    endtask

    task automatic ev(logic ps, logic pp, logic [1:0] mgr);
        push_vld = ps; pop_vld = pp;
        push_qnum = 11'd5; pop_qnum = 11'd5; push_mgr = mgr; pop_mgr = mgr;
        tick();
        push_vld = 0; pop_vld = 0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        tick();
        rd(0, d);  chk("R11 status after reset", d, 32'h0);
        rd(18, d); chk("R11 depth after reset", d, 32'h0);
        rd(19, d); chk("R11 watermark after reset", d, 32'h0);

        wr(16, 32'd3);
        wr(17, 32'h8000_0000 | (32'd1 << 11) | 32'd5);
        wr(20, 32'd5);
        wr(21, (32'd2 << 11) | 32'd5);
        rd(17, d); chk("R1 select readback", d, 32'h8000_0805);

        ev(1, 0, 2'd2);
        rd(18, d); chk("R1 manager mismatch ignored", d, 32'h0);
        rd(22, d); chk("R3 disabled monitor ignores push", d, 32'h0);
        chk("R3 disabled event low", 32'(evt_level), 32'h0);

        for (int i = 0; i < 10; i++) begin
            ev(VEC[i][10] | VEC[i][9] ? VEC[i][9] : 1'b0, VEC[i][10], 2'd1);
            chk("R4 up event level", 32'(evt_level[0]), 32'(VEC[i][8]));
            rd(18, d); chk("R2 depth count", d, 32'(VEC[i][7:0]));
        end
        rd(19, d); chk("R6 up watermark max", d, 32'd4);
        rd(0, d);  chk("R8 live status", d, 32'h1);

        rd(1, d); chk("R9 sticky set", d, 32'h1);
        rd(1, d); chk("R9 sticky cleared by read", d, 32'h0);
        ev(0, 1, 2'd1);
        chk("R4 event recedes", 32'(evt_level[0]), 32'h0);
        reg_rd = 1; reg_addr = ADDR_W'(1);
        push_vld = 1; push_qnum = 11'd5; push_mgr = 2'd1;
        tick();
        reg_rd = 0; push_vld = 0;
        chk("R9 read returns pre-clear value", reg_rdata, 32'h0);
        rd(1, d); chk("R9 coincident event kept", d, 32'h1);

        wr(21, 32'hC000_0000 | (32'd2 << 11) | 32'd5);
        wr(2, 32'h2);
        rd(23, d); chk("R10 down watermark all-ones", d, 32'h0000_FFFF);
        wr(22, 32'd7);
        rd(23, d); chk("R7 write updates watermark", d, 32'd7);
        chk("R7 write raises no event", 32'(evt_level[1]), 32'h0);
        ev(0, 1, 2'd2); chk("R5 depth 6 no event", 32'(evt_level[1]), 32'h0);
        ev(0, 1, 2'd2); chk("R5 depth 5 event", 32'(evt_level[1]), 32'h1);
        ev(0, 1, 2'd2); chk("R5 depth 4 event", 32'(evt_level[1]), 32'h1);
        ev(1, 0, 2'd2); chk("R5 depth 5 holds", 32'(evt_level[1]), 32'h1);
        ev(1, 0, 2'd2); chk("R5 depth 6 recedes", 32'(evt_level[1]), 32'h0);
        rd(22, d); chk("R7 counting continues", d, 32'd6);
        rd(23, d); chk("R6 down watermark min", d, 32'd4);
        rd(1, d);  chk("R9 sticky bit for monitor 1", d, 32'h2);

        wr(18, 32'h0000_FFFF);
        ev(1, 0, 2'd1);
        rd(18, d); chk("R2 saturate at max", d, 32'h0000_FFFF);
        wr(2, 32'h1);
        chk("R10 event cleared", 32'(evt_level[0]), 32'h0);
        rd(18, d); chk("R10 depth zero", d, 32'h0);
        rd(19, d); chk("R10 up watermark zero", d, 32'h0);
        ev(0, 1, 2'd1);
        rd(18, d); chk("R2 saturate at zero", d, 32'h0);

        wr(17, (32'd1 << 11) | 32'd5);
        tick();
        chk("R3 event low after disable", 32'(evt_level[0]), 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule